// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Slave

This block lets a host on a standard-mode (100 kbit/s or slower) two-wire serial bus set and read back a small bank of 8-bit control registers in a clock-generator device. The bus lines are brought in as plain inputs and sampled by a much faster system clock. The slave pulls SDA low through an open-drain output enable. It never stretches SCL. It does not answer a general call and does not take part in arbitration.

Only whole-bank transfers are supported. A write is the device address, then a command byte, then a byte-count byte, then data. The slave acknowledges the command and count bytes and then throws them away. Data always fills register 0 first and moves upward. A read returns a count byte followed by every register, lowest index first. The register bank leaves the block as one parallel bus with a one-cycle strobe for each byte that gets updated. A 5-bit frequency/spread selection code is gathered from scattered bits of register 0 and driven out on its own port.

Top module: `cfg_serial_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by holding SDA low. Any other address byte gets no acknowledge, and the slave stays silent until the next START.
- R2: In a write, the first two bytes after the address (command and byte count) are each acknowledged, and their values change no register.
- R3: Each write data byte after the count is acknowledged and stored in register 0, 1, 2 and so on, in that order. Byte n sits at cfg_regs[8n+7:8n]. cfg_wr_stb[n] pulses for exactly one cycle each time byte n is stored, and no more than one strobe bit is high at a time.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values, and the rest keep their old values. A register byte changes only in the cycle its strobe is high.
- R5: Write data bytes past the last register are acknowledged and discarded.
- R6: A read returns, MSB first, a count byte equal to 6 (the number of registers), then registers 0 to 5 in order. Any further acknowledged bytes read as 0xFF.
- R7: When the host does not acknowledge a read byte, the slave releases SDA at once and stays released until the next START.
- R8: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xC3, 0xF0, 0x0F, 0xFF and 0x5A. sda_oe is low and no strobe is high.
- R9: sel_code[4:0] equals {reg0[2], reg0[7], reg0[6], reg0[5], reg0[4]}, with bit 4 the most significant bit of the code.
- R10: sda_oe changes only while SCL is low. An acknowledge is held low for the whole ninth clock.
- R11: A START or STOP received partway through a byte aborts the transfer without storing that byte. After a START the next byte is treated as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_regs | output | 48 | Register bank, byte n at bits 8n+7:8n |
| cfg_wr_stb | output | 6 | One-cycle pulse per register byte update |
| sel_code | output | 5 | Frequency/spread selection code gathered from register 0 |

## Verification
The assertions assume the host behaves well on the bus. It never raises SDA for a START or STOP while the slave holds the line low. It keeps each SCL phase much longer than the synchronizer delay. It changes SDA only while SCL is low, except to signal START or STOP. The bench drives the bus from tasks that hold SCL in each phase for twelve system clocks and switch data only in the low phase. Every abort it injects is a START or STOP made while the slave has released the line.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 2;   // command + byte count, discarded on write

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRX,
    ST_WACK,
    ST_TX,
    ST_RACK
  } eng_state_t;
endpackage

// File: rtl/cfgslv_linesync.sv
module cfgslv_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_prev_q;
  logic              sda_prev_q;
  logic [STAGES-1:0] scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        scl_pipe_d = scl_in;
        sda_pipe_d = sda_in;
      end
    end else begin : g_many
      always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_in};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_pipe_q[STAGES-1];
    sda_s     = sda_pipe_q[STAGES-1];
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end
endmodule

// File: rtl/cfgslv_engine.sv
module cfgslv_engine
  import cfgslv_pkg::*;
#(
  parameter int         NREGS     = 6,
  parameter logic [6:0] DEV_ADDR7 = 7'h69,
  localparam int        IDX_W     = $clog2(NREGS + HDR_BYTES + 1),
  localparam int        PTR_W     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sda_s,
  input  logic                      scl_rise,
  input  logic                      scl_fall,
  input  logic                      start_det,
  input  logic                      stop_det,
  input  logic [BYTE_W*NREGS-1:0]   rd_regs,
  output logic                      sda_oe,
  output logic                      wr_req,
  output logic [PTR_W-1:0]          wr_ptr,
  output logic [BYTE_W-1:0]         wr_byte
);
  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(NREGS + HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NREGS + HDR_BYTES);

  eng_state_t        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rnw_q, rnw_d;
  logic              acked_q, acked_d;
  logic              oe_q, oe_d;
  logic [7:0]        rd_sel;

  // byte offered on a read: count first, then registers, then all ones
  always_comb begin
    rd_sel = 8'hFF;
    if (idx_q == '0) rd_sel = 8'(NREGS);
    for (int i = 0; i < NREGS; i++) begin
      if (idx_q == IDX_W'(i + 1)) rd_sel = rd_regs[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    rnw_d   = rnw_q;
    acked_d = acked_q;
    oe_d    = oe_q;
    wr_req  = 1'b0;
    wr_ptr  = PTR_W'(idx_q - IDX_HDR);
    wr_byte = sh_q;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_WRX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR7) begin
                oe_d    = 1'b1;
                rnw_d   = sh_q[0];
                idx_d   = '0;
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              oe_d    = 1'b1;
              state_d = ST_WACK;
              if (idx_q >= IDX_HDR && idx_q < IDX_LAST) wr_req = 1'b1;
              if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rnw_q) begin
              sh_d    = rd_sel;
              oe_d    = ~rd_sel[7];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_WRX;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_WRX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d    = 1'b0;
              acked_d = 1'b0;
              state_d = ST_RACK;
              if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
            end else begin
              sh_d  = {sh_q[6:0], 1'b1};
              oe_d  = ~sh_q[6];
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            acked_d = ~sda_s;
          end else if (scl_fall) begin
            if (acked_q) begin
              sh_d    = rd_sel;
              oe_d    = ~rd_sel[7];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      rnw_q   <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      rnw_q   <= rnw_d;
      acked_q <= acked_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank
  import cfgslv_pkg::*;
#(
  parameter int                      NREGS     = 6,
  parameter logic [BYTE_W*NREGS-1:0] RESET_VAL = 48'h5A_FF_0F_F0_C3_00,
  localparam int                     PTR_W     = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_req,
  input  logic [PTR_W-1:0]        wr_ptr,
  input  logic [BYTE_W-1:0]       wr_byte,
  output logic [BYTE_W*NREGS-1:0] regs,
  output logic [NREGS-1:0]        wr_stb,
  output logic [4:0]              sel_code
);
  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_byte
      logic hit;
      logic [BYTE_W-1:0] byte_q;
      logic stb_q;
      assign hit = wr_req && (wr_ptr == PTR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= RESET_VAL[g*BYTE_W +: BYTE_W];
          stb_q  <= 1'b0;
        end else begin
          stb_q <= hit;
          if (hit) byte_q <= wr_byte;
        end
      end
      assign regs[g*BYTE_W +: BYTE_W] = byte_q;
      assign wr_stb[g] = stb_q;
    end
  endgenerate

  // selection field order: bit 2 is the top, then 7 down to 4
  assign sel_code = {regs[2], regs[7], regs[6], regs[5], regs[4]};
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgslv_pkg::*;
#(
  parameter int                      NREGS       = 6,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [6:0]              DEV_ADDR7   = 7'h69,
  parameter logic [BYTE_W*NREGS-1:0] RESET_VAL   = 48'h5A_FF_0F_F0_C3_00,
  localparam int                     PTR_W       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    sda_oe,
  output logic [BYTE_W*NREGS-1:0] cfg_regs,
  output logic [NREGS-1:0]        cfg_wr_stb,
  output logic [4:0]              sel_code
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_req;
  logic [PTR_W-1:0]  wr_ptr;
  logic [BYTE_W-1:0] wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cfgslv_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfgslv_engine #(.NREGS(NREGS), .DEV_ADDR7(DEV_ADDR7)) u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_regs   (cfg_regs),
    .sda_oe    (sda_oe),
    .wr_req    (wr_req),
    .wr_ptr    (wr_ptr),
    .wr_byte   (wr_byte)
  );

  cfgslv_regbank #(.NREGS(NREGS), .RESET_VAL(RESET_VAL)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_req   (wr_req),
    .wr_ptr   (wr_ptr),
    .wr_byte  (wr_byte),
    .regs     (cfg_regs),
    .wr_stb   (cfg_wr_stb),
    .sel_code (sel_code)
  );
endmodule

// File: rtl/cfgslv_checker.sv
module cfgslv_checker #(
  parameter int NREGS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               start_det,
  input logic               stop_det,
  input logic               sda_oe,
  input logic [8*NREGS-1:0] cfg_regs,
  input logic [NREGS-1:0]   cfg_wr_stb
);
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_start_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_stb_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr_stb));

  genvar g;
  generate
    for (g = 0; g < NREGS; g++) begin : g_hold
      assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs[g*8 +: 8]) |-> cfg_wr_stb[g]);
    end
  endgenerate
endmodule

bind cfg_serial_slave cfgslv_checker #(.NREGS(NREGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_oe     (sda_oe),
  .cfg_regs   (cfg_regs),
  .cfg_wr_stb (cfg_wr_stb)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int H = 12;  // system clocks per SCL phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_h = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_oe;
  logic [47:0] cfg_regs;
  logic [5:0]  cfg_wr_stb;
  logic [4:0]  sel_code;
  logic        sda_bus;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [7:0] exp_regs [6];
  int         exp_stb  [6];
  int         seen_stb [6];
  logic [7:0] wbuf     [10];
  int         oe_bad = 0;
  logic       scl_prev = 1'b1;
  logic       oe_prev = 1'b0;

  assign sda_bus = sda_h & ~sda_oe;

  always #2 clk = ~clk;

  cfg_serial_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_h),
    .sda_in     (sda_bus),
    .sda_oe     (sda_oe),
    .cfg_regs   (cfg_regs),
    .cfg_wr_stb (cfg_wr_stb),
    .sel_code   (sel_code)
  );

  // monitors sampled away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < 6; i++) if (cfg_wr_stb[i]) seen_stb[i] = seen_stb[i] + 1;
    if (rst_n && scl_h && scl_prev && (sda_oe != oe_prev)) oe_bad = oe_bad + 1;
    scl_prev = scl_h;
    oe_prev  = sda_oe;
  end

  function automatic logic [4:0] exp_sel(input logic [7:0] b);
    return {b[2], b[7], b[6], b[5], b[4]};
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return 8'd6;
    if (k <= 6) return exp_regs[k-1];
    return 8'hFF;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(H);
    scl_h = 1'b1; tick(H);
    sda_h = 1'b0; tick(H);
    scl_h = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(H);
    scl_h = 1'b1; tick(H);
    sda_h = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; tick(H);
      scl_h = 1'b1; tick(H);
      scl_h = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a_mid, a_late;
    send_bits(b, 8);
    sda_h = 1'b1; tick(H);
    scl_h = 1'b1; tick(2);
    a_mid = ~sda_bus; tick(H - 3);
    a_late = ~sda_bus; tick(1);
    scl_h = 1'b0;
    ack = a_mid & a_late;  // held across the whole ninth clock
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_h = 1'b1; tick(H / 2);
      b[i] = sda_bus; tick(H - H / 2);
      scl_h = 1'b0;
    end
    sda_h = ~host_ack; tick(H);
    scl_h = 1'b1; tick(H);
    scl_h = 1'b0;
    sda_h = 1'b1;
  endtask

  task automatic check_bank(input string req);
    logic [47:0] e;
    for (int i = 0; i < 6; i++) e[i*8 +: 8] = exp_regs[i];
    chk(cfg_regs === e, req, cfg_regs, e);
    chk(sel_code === exp_sel(exp_regs[0]), "R9 sel_code", sel_code, exp_sel(exp_regs[0]));
  endtask

  task automatic check_strobes(input string req);
    for (int i = 0; i < 6; i++)
      chk(seen_stb[i] == exp_stb[i], req, seen_stb[i], exp_stb[i]);
  endtask

  // write transaction with n data bytes from wbuf
  task automatic wr_txn(input int n, input logic [7:0] cmd, input logic [7:0] cnt);
    logic a;
    logic all_ack = 1'b1;
    bus_start();
    send_byte(8'hD2, a); all_ack &= a;
    send_byte(cmd, a);
    chk(a, "R2 command byte ack", a, 1);
    send_byte(cnt, a);
    chk(a, "R2 count byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      all_ack &= a;
      if (i < 6) begin
        exp_regs[i] = wbuf[i];
        exp_stb[i]++;
      end
    end
    bus_stop();
    chk(all_ack, (n > 6) ? "R5 ack beyond last" : "R3 data ack", all_ack, 1);
    tick(4);
    check_bank((n < 6) ? "R4 partial write bank" : "R3 bank contents");
  endtask

  // read transaction of n bytes, last one not acknowledged
  task automatic rd_txn(input int n);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(b === exp_rd(k), (k == 0) ? "R6 count byte" : "R6 read data", b, exp_rd(k));
    end
    tick(H / 2);
    chk(sda_oe === 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin
      exp_stb[i] = 0;
      seen_stb[i] = 0;
    end
    exp_regs[0] = 8'h00; exp_regs[1] = 8'hC3; exp_regs[2] = 8'hF0;
    exp_regs[3] = 8'h0F; exp_regs[4] = 8'hFF; exp_regs[5] = 8'h5A;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R8 reset state
    check_bank("R8 reset bank");
    chk(sda_oe === 1'b0, "R8 sda_oe at reset", sda_oe, 0);
    chk(cfg_wr_stb === 6'd0, "R8 strobes at reset", cfg_wr_stb, 0);

    // R1 foreign addresses are not acknowledged; data after them is ignored
    bus_start();
    send_byte(8'hA0, a);
    chk(!a, "R1 foreign address nack", a, 0);
    send_byte(8'h12, a);
    chk(!a, "R1 silent after foreign address", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a);
    chk(!a, "R1 near-miss address nack", a, 0);
    bus_stop();
    tick(4);
    check_bank("R1 bank untouched");

    // R2 R3 full write with odd header values
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h11 * 8'(i + 1);
    wr_txn(6, 8'hFF, 8'h00);
    check_strobes("R3 strobe count");
    rd_txn(7);

    // R9 selection code from a chosen register 0
    wbuf[0] = 8'h74;
    wr_txn(1, 8'h00, 8'h01);
    chk(sel_code === 5'h17, "R9 sel_code directed", sel_code, 5'h17);

    // R4 partial write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    wr_txn(2, 8'h55, 8'h06);

    // R5 beyond the last register
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'hE0 + i);
    wr_txn(9, 8'h01, 8'h09);
    check_strobes("R5 strobe count");

    // R6 extra reads return all ones; R7 early nack then a fresh read
    rd_txn(9);
    rd_txn(3);
    rd_txn(7);

    // R11 repeated START in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h06, a);
    send_bits(8'h5F, 4);
    rd_txn(7);
    // R11 STOP in the middle of a data byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h06, a);
    send_byte(8'h99, a);
    exp_regs[0] = 8'h99; exp_stb[0]++;
    send_bits(8'h00, 3);
    scl_h = 1'b1; tick(H);
    sda_h = 1'b1; tick(H);
    tick(4);
    check_bank("R11 abort keeps bank");
    check_strobes("R11 strobe count");

    // constrained random mix
    for (int it = 0; it < 16; it++) begin
      if ($urandom % 2 == 0) begin
        int n;
        n = int'($urandom % 9);
        for (int i = 0; i < 9; i++) wbuf[i] = 8'($urandom);
        wr_txn(n, 8'($urandom), 8'($urandom));
      end else begin
        rd_txn(1 + int'($urandom % 8));
      end
    end
    check_strobes("R3 random strobe count");
    chk(oe_bad == 0, "R10 sda_oe steady while SCL high", oe_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule